// File: doc/BRIEF.md
# Audio Transmit FIFO with Level and Underrun Interrupts

This block is the register-mapped front end of an audio serializer's transmit path. Software reaches it over a simple 32-bit register bus with one word per address step. It writes sample words into a data port, and those words are queued in a FIFO. The serializer drains the FIFO through a head-word/pop interface. The block also publishes the serializer's configuration fields: transmit enable, clock ratio, sample resolution and channel select.

Two status flags follow the FIFO occupancy on every cycle. The underrun flag is set while the FIFO is empty. The low flag is set while the occupancy is under a threshold, and that threshold is the FIFO depth shifted right by a 4-bit level field. Software can clear either flag for one cycle by writing 1 to its bit, but a flag whose condition still holds comes back on the following cycle. A single interrupt line is raised when the global interrupt enable is on and some flag is both set and unmasked.

The FIFO depth is `2**DEPTH_LOG2` words. It is kept small by default and can be raised to 8192 by setting `DEPTH_LOG2 = 13`. Software writes the left word, then the right word, of each frame.

Top module: `audfifo_tx`

## Requirements
- R1: After reset the configuration and mask registers read 0, the version register reads `VERSION`, `irq` is low and `ser_avail` is low.
- R2: Word index (`bus_addr[ADDR_W-1:2]`) 0 is the read-only version register, 1 is configuration, 2 is the interrupt mask (bits 1:0, upper bits read 0), and 3 is the interrupt status. Indices 4 to 7 are write-only data ports that read as 0. Writes to index 0 are ignored.
- R3: The configuration fields are: transmit enable at bit 0, interrupt enable at bit 1, ratio at bits 15:8, resolution at bits 21:16, level at bits 27:24 and channel select at bits 31:28. All other bits read 0. Each field drives its output port from the cycle after the write.
- R4: Status bit 0 (underrun) reads 1 exactly when the FIFO was empty on the previous cycle.
- R5: Status bit 1 (low) reads 1 exactly when the previous cycle's occupancy was below `DEPTH >> level`. Level 0 gives the full depth, and a level at or above `DEPTH_LOG2+1` gives a threshold of 0, so the flag never sets.
- R6: Writing status with a 1 in a bit position clears that bit for one cycle. The bit sets again on the next cycle if its condition still holds. A 0 in a bit position leaves that bit alone.
- R7: `irq` is high exactly when interrupt enable (configuration bit 1) is set and the status AND mask is non-zero.
- R8: A write to any data port pushes the written word. `ser_word` shows the oldest word, `ser_pop` removes it, and words leave in the order they were written.
- R9: A data write while the FIFO holds `DEPTH` words is dropped. A pop while the FIFO is empty is ignored.
- R10: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave the occupancy unchanged, and both words stay in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word index in bits ADDR_W-1:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, otherwise 0 |
| ser_pop | input | 1 | Serializer removes the head word |
| ser_word | output | 32 | Head word of the FIFO |
| ser_avail | output | 1 | FIFO is not empty |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_chan | output | 4 | Channel select field |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the FIFO one word under and then exactly to a halved threshold. A design with an off-by-one comparison or a shift in the wrong direction shows the low flag on the wrong side of the boundary. It also sets a level large enough to shift the threshold to zero; a design that wraps the shift instead raises a low flag on an empty FIFO. Clearing a status bit on an empty FIFO must read 0 once and 1 on the next cycle, which catches a flag that sticks at 0 and a write that clears the wrong bit. Overfilling, popping when empty and a simultaneous push and pop are each followed by draining the FIFO word by word, so a lost, duplicated or reordered word shows up directly.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;

    localparam int WORD_W   = 32;
    localparam int STAT_W   = 2;
    localparam int ST_UNDER = 0;
    localparam int ST_LOW   = 1;

    localparam int IDX_VER  = 0;
    localparam int IDX_CFG  = 1;
    localparam int IDX_MSK  = 2;
    localparam int IDX_STS  = 3;
    localparam int IDX_DAT0 = 4;
    localparam int IDX_DAT3 = 7;

    localparam int POS_TXEN  = 0;
    localparam int POS_INTEN = 1;
    localparam int RATIO_LSB = 8;
    localparam int RATIO_W   = 8;
    localparam int RES_LSB   = 16;
    localparam int RES_W     = 6;
    localparam int LVL_LSB   = 24;
    localparam int LVL_W     = 4;
    localparam int CHAN_LSB  = 28;
    localparam int CHAN_W    = 4;

    typedef struct packed {
        logic               tx_en;
        logic               int_en;
        logic [RATIO_W-1:0] ratio;
        logic [RES_W-1:0]   res;
        logic [LVL_W-1:0]   level;
        logic [CHAN_W-1:0]  chan;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.tx_en  = w[POS_TXEN];
        c.int_en = w[POS_INTEN];
        c.ratio  = w[RATIO_LSB +: RATIO_W];
        c.res    = w[RES_LSB +: RES_W];
        c.level  = w[LVL_LSB +: LVL_W];
        c.chan   = w[CHAN_LSB +: CHAN_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_TXEN]              = c.tx_en;
        w[POS_INTEN]             = c.int_en;
        w[RATIO_LSB +: RATIO_W]  = c.ratio;
        w[RES_LSB +: RES_W]      = c.res;
        w[LVL_LSB +: LVL_W]      = c.level;
        w[CHAN_LSB +: CHAN_W]    = c.chan;
        return w;
    endfunction

endpackage

// File: rtl/audfifo_store.sv
module audfifo_store
    import audfifo_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6,
    localparam int CNT_W = DEPTH_LOG2 + 1,
    localparam int DEPTH = 1 << DEPTH_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] head_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = {1'b1, {DEPTH_LOG2{1'b0}}};

    typedef struct packed {
        logic [DEPTH_LOG2-1:0] wr_ptr;
        logic [DEPTH_LOG2-1:0] rd_ptr;
        logic [CNT_W-1:0]      cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push_i && (st_q.cnt != FULL_CNT);
        do_pop  = pop_i && (st_q.cnt != '0);
        st_d    = st_q;
        if (do_push) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (do_pop)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= push_data_i;
    end

    assign head_o = mem_q[st_q.rd_ptr];
    assign cnt_o  = st_q.cnt;

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= FULL_CNT);

    p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == FULL_CNT && push_i && !pop_i) |=> (cnt_o == FULL_CNT));

    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && pop_i && !push_i) |=> (cnt_o == '0));

    p_pushpop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && cnt_o != '0 && cnt_o != FULL_CNT) |=> $stable(cnt_o));

endmodule

// File: rtl/audfifo_flags.sv
module audfifo_flags
    import audfifo_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6,
    localparam int CNT_W = DEPTH_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              int_en_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = {1'b1, {DEPTH_LOG2{1'b0}}};

    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0]  thr;
    logic [STAT_W-1:0] cond;

    always_comb begin
        thr            = FULL_CNT >> level_i;
        cond           = '0;
        cond[ST_UNDER] = (cnt_i == '0);
        cond[ST_LOW]   = (cnt_i < thr);
        st_d.stat      = cond & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign irq_o  = int_en_i && |(st_q.stat & mask_i);

    p_under_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_i[ST_UNDER]))
            |-> (stat_o[ST_UNDER] == ($past(cnt_i) == '0)));

    p_low_never_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_i) == FULL_CNT) |-> !stat_o[ST_LOW]);

    p_clear_under_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[ST_UNDER] |=> !stat_o[ST_UNDER]);

    p_clear_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[ST_LOW] |=> !stat_o[ST_LOW]);

endmodule

// File: rtl/audfifo_csr.sv
module audfifo_csr
    import audfifo_pkg::*;
#(
    parameter int                ADDR_W  = 5,
    parameter logic [WORD_W-1:0] VERSION = 32'h0001_0200,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [STAT_W-1:0] stat_i,
    output cfg_t              cfg_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              push_o,
    output logic [WORD_W-1:0] push_data_o,
    output logic [STAT_W-1:0] clr_o
);

    typedef struct packed {
        cfg_t              cfg;
        logic [STAT_W-1:0] mask;
    } st_t;

    st_t st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic wr, rd, is_data;

    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        wr      = bus_en && bus_we;
        rd      = bus_en && !bus_we;
        is_data = (idx >= IDX_W'(IDX_DAT0)) && (idx <= IDX_W'(IDX_DAT3));
        st_d    = st_q;
        if (wr && idx == IDX_W'(IDX_CFG)) st_d.cfg  = cfg_from_word(bus_wdata);
        if (wr && idx == IDX_W'(IDX_MSK)) st_d.mask = bus_wdata[STAT_W-1:0];

        push_o      = wr && is_data;
        push_data_o = bus_wdata;
        clr_o       = (wr && idx == IDX_W'(IDX_STS)) ? bus_wdata[STAT_W-1:0] : '0;

        bus_rdata = '0;
        if (rd) begin
            case (idx)
                IDX_W'(IDX_VER): bus_rdata = VERSION;
                IDX_W'(IDX_CFG): bus_rdata = cfg_to_word(st_q.cfg);
                IDX_W'(IDX_MSK): bus_rdata = WORD_W'(st_q.mask);
                IDX_W'(IDX_STS): bus_rdata = WORD_W'(stat_i);
                default:         bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign mask_o = st_q.mask;

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && idx == IDX_W'(IDX_CFG)) |=> $stable(cfg_o));

endmodule

// File: rtl/audfifo_tx.sv
module audfifo_tx
    import audfifo_pkg::*;
#(
    parameter int                ADDR_W     = 5,
    parameter int                DEPTH_LOG2 = 6,
    parameter logic [WORD_W-1:0] VERSION    = 32'h0001_0200,
    localparam int CNT_W = DEPTH_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ser_pop,
    output logic [31:0]       ser_word,
    output logic              ser_avail,
    output logic              cfg_tx_en,
    output logic [7:0]        cfg_ratio,
    output logic [5:0]        cfg_res,
    output logic [3:0]        cfg_chan,
    output logic              irq
);

    cfg_t              cfg;
    logic [STAT_W-1:0] mask, stat, clr;
    logic              push;
    logic [WORD_W-1:0] push_data;
    logic [CNT_W-1:0]  cnt;

    audfifo_csr #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_csr (
        .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .stat_i(stat), .cfg_o(cfg), .mask_o(mask), .push_o(push),
        .push_data_o(push_data), .clr_o(clr)
    );

    audfifo_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
        .clk, .rst_n, .push_i(push), .push_data_i(push_data),
        .pop_i(ser_pop), .head_o(ser_word), .cnt_o(cnt)
    );

    audfifo_flags #(.DEPTH_LOG2(DEPTH_LOG2)) u_flags (
        .clk, .rst_n, .cnt_i(cnt), .level_i(cfg.level), .clr_i(clr),
        .mask_i(mask), .int_en_i(cfg.int_en), .stat_o(stat), .irq_o(irq)
    );

    assign ser_avail = (cnt != '0);
    assign cfg_tx_en = cfg.tx_en;
    assign cfg_ratio = cfg.ratio;
    assign cfg_res   = cfg.res;
    assign cfg_chan  = cfg.chan;

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cfg.int_en && (stat & mask) != '0));

    p_avail_under_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr[ST_UNDER]) && $past(ser_avail)) |-> !stat[ST_UNDER]);

endmodule

// File: tb/test_audfifo_tx.sv
module test_audfifo_tx;

    localparam int CLK_PERIOD = 10;
    localparam int DLOG = 6;
    localparam int DEPTH = 1 << DLOG;
    localparam logic [31:0] VER = 32'h0001_0200;
    localparam logic [4:0] A_VER = 5'h00, A_CFG = 5'h04, A_MSK = 5'h08,
                           A_STS = 5'h0C, A_D0 = 5'h10, A_D3 = 5'h1C;

    logic clk = 0, rst_n = 0;
    logic bus_en = 0, bus_we = 0, ser_pop = 0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, ser_word;
    logic ser_avail, cfg_tx_en, irq;
    logic [7:0] cfg_ratio;
    logic [5:0] cfg_res;
    logic [3:0] cfg_chan;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audfifo_tx #(.ADDR_W(5), .DEPTH_LOG2(DLOG), .VERSION(VER)) i_audfifo_tx (
        .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .ser_pop, .ser_word, .ser_avail, .cfg_tx_en, .cfg_ratio, .cfg_res,
        .cfg_chan, .irq
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        chk(req, ser_word, exp);
        ser_pop = 1;
        @(posedge clk); @(negedge clk);
        ser_pop = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CFG, d); chk("R1 cfg", d, 0);
        rd(A_MSK, d); chk("R1 mask", d, 0);
        rd(A_VER, d); chk("R1 version", d, VER);
        chk("R1 irq", irq, 0);
        chk("R1 avail", ser_avail, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, d); chk("R3 unused bits read 0", d, 32'hFF3F_FF03);
        wr(A_CFG, 32'h5A2B_7C01);
        rd(A_CFG, d); chk("R3 cfg readback", d, 32'h5A2B_7C01);
        chk("R3 tx_en", cfg_tx_en, 1);
        chk("R3 ratio", cfg_ratio, 8'h7C);
        chk("R3 res", cfg_res, 6'h2B);
        chk("R3 chan", cfg_chan, 4'h5);
        wr(A_VER, 32'h1234_5678);
        rd(A_VER, d); chk("R2 version write ignored", d, VER);
        rd(A_D0, d); chk("R2 data port reads 0", d, 0);
        chk("R2 read does not push", ser_avail, 0);
        wr(A_MSK, 32'hFFFF_FFFF);
        rd(A_MSK, d); chk("R2 mask width", d, 32'h3);
        wr(A_MSK, 0); wr(A_CFG, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        settle();
        rd(A_STS, d); chk("R4 R5 empty level0", d, 3);
        wr(A_CFG, 32'h0100_0000);
        for (int i = 0; i < DEPTH/2 - 1; i++) wr(A_D0, 32'h100 + i);
        settle();
        rd(A_STS, d); chk("R5 one under threshold", d, 2);
        wr(A_D0, 32'h100 + DEPTH/2 - 1);
        settle();
        rd(A_STS, d); chk("R5 at threshold", d, 0);
        wr(A_CFG, 32'h0700_0000);
        settle();
        rd(A_STS, d); chk("R5 level shifts to zero", d, 0);
        for (int i = 0; i < DEPTH/2; i++) pop_chk("R8 order", 32'h100 + i);
        settle();
        rd(A_STS, d); chk("R4 R5 empty level7", d, 1);
        wr(A_CFG, 0);
        settle();
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(A_STS, 32'h1);
        rd(A_STS, d); chk("R6 clear bit0 once", d, 2);
        settle();
        rd(A_STS, d); chk("R6 bit0 resets", d, 3);
        wr(A_STS, 32'h3);
        rd(A_STS, d); chk("R6 clear both", d, 0);
        settle();
        rd(A_STS, d); chk("R6 both reset", d, 3);
    endtask

    task automatic t_irq();
        wr(A_MSK, 1); wr(A_CFG, 2);
        chk("R7 underrun irq", irq, 1);
        wr(A_CFG, 0);
        chk("R7 global enable off", irq, 0);
        wr(A_CFG, 32'h0700_0002); wr(A_MSK, 2);
        settle();
        chk("R7 masked flag no irq", irq, 0);
        wr(A_MSK, 3);
        chk("R7 unmasked irq", irq, 1);
        wr(A_STS, 3);
        chk("R7 R6 irq drops on clear", irq, 0);
        settle();
        chk("R7 R6 irq returns", irq, 1);
        wr(A_MSK, 0); wr(A_CFG, 0);
        chk("R7 off after cleanup", irq, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) wr(A_D0, 32'hA000 + i);
        wr(A_D0, 32'hDEAD_BEEF);
        for (int i = 0; i < DEPTH; i++) pop_chk("R9 R8 full drain", 32'hA000 + i);
        chk("R9 overflow dropped", ser_avail, 0);
        ser_pop = 1; settle(); ser_pop = 0;
        chk("R9 pop on empty", ser_avail, 0);
        wr(A_D3, 32'h77);
        chk("R9 R8 push after empty pop", ser_word, 32'h77);
        pop_chk("R8 data port 3", 32'h77);
        chk("R8 empty again", ser_avail, 0);
    endtask

    task automatic t_pushpop();
        wr(A_D0, 32'hB0); wr(A_D0, 32'hB1);
        chk("R10 head before", ser_word, 32'hB0);
        bus_en = 1; bus_we = 1; bus_addr = A_D0; bus_wdata = 32'hB2; ser_pop = 1;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_we = 0; ser_pop = 0;
        pop_chk("R10 second word", 32'hB1);
        pop_chk("R10 third word", 32'hB2);
        chk("R10 occupancy kept", ser_avail, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_status();
        t_clear();
        t_irq();
        t_full();
        t_pushpop();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule